// File: doc/BRIEF.md
# Single-Wire Trim Code Controller

This controller turns one control line into a 7-bit trim code. Outside the block the line is resolved into three levels and a separate over-voltage flag. A sustained low excursion raises the code by one step. A sustained high excursion lowers it by one step. Holding the over-voltage flag copies the current code into non-volatile storage.

Every pulse is qualified in units of an external microsecond-scale tick. Short pulses are dropped, and consecutive counts must be separated by a minimum spacing. The first qualified pulse after power-up is thrown away, because the level detectors come up in an unknown state. The code saturates at both ends.

At power-on the code is read from the storage before any pulse is acted on. While a store is in progress the line is ignored.

Top module: `trim_ctl_top`

## Requirements
- R1: After reset the block issues one `nvmRdEn` cycle and loads `nvmRdData` into `trimCode` before any pulse is acted on. During reset `trimCode` is 0 and `storing` is 0.
- R2: With `cntEn`=1, holding the line low (`lvlLow`=1, `lvlHigh`=0) for ACCEPT_TICKS ticks raises `trimCode` (unsigned binary) by one. The count is taken on the tick that completes the width, once per excursion.
- R3: With `cntEn`=1, holding the line high (`lvlHigh`=1, `lvlLow`=0) for ACCEPT_TICKS ticks lowers `trimCode` by one. Both flags high, or both low, is the mid level.
- R4: A low or high excursion that ends before ACCEPT_TICKS ticks changes nothing.
- R5: A qualified pulse that completes fewer than GAP_TICKS ticks after the previous consumed pulse is dropped.
- R6: An increment at 127 and a decrement at 0 leave `trimCode` unchanged. The code never wraps.
- R7: The first qualified pulse after reset is consumed without changing `trimCode`.
- R8: With `cntEn`=0, qualified pulses leave `trimCode` unchanged.
- R9: Holding `progFlag` for PROG_TICKS ticks issues one `nvmWrEn` cycle carrying `trimCode` on `nvmWrData`, whatever `cntEn` is. `storing` stays 1 from the strobe until `nvmBusy` falls. A shorter hold writes nothing.
- R10: While `storing`=1, line pulses are ignored, and a level that is held across the end of the store must first return to mid. `progFlag` must fall before another write can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| tick | input | 1 | One-cycle time-base strobe |
| cntEn | input | 1 | Counting enable |
| lvlLow | input | 1 | Line detected at the low level |
| lvlHigh | input | 1 | Line detected at the high level |
| progFlag | input | 1 | Line above the program threshold |
| nvmRdData | input | CODE_W | Stored code read from the storage |
| nvmBusy | input | 1 | Storage write in progress |
| trimCode | output | CODE_W | Current trim setting |
| nvmRdEn | output | 1 | Read request strobe |
| nvmWrEn | output | 1 | Write strobe |
| nvmWrData | output | CODE_W | Code to be written |
| storing | output | 1 | Store sequence active |

## Verification
The bench sweeps the code across the full range in both directions, pushing past each end. A counter that wraps would jump between 0 and 127 at the ends.

It sends pulses one tick short of the accept width, and a high excursion followed at once by a low one inside the spacing window. A design without width qualification or spacing would count these pulses.

It checks that the first pulse after each reset is swallowed, and that counting is inhibited while disabled. It holds the program flag through a whole store with a line pulse in the middle. A design that re-armed on a held flag would write twice, and one that listened during the store would move the code.

It also resets a second time so the code must come back from storage.

// File: rtl/trim_pkg.sv
package trim_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ldCode;
    logic incCode;
    logic decCode;
  } trimStrobe_t;

  typedef enum logic [2:0] {
    ST_RDREQ,
    ST_RDCAP,
    ST_RUN,
    ST_WRSTB,
    ST_WRSETTLE,
    ST_WRWAIT
  } trimState_t;
endpackage

// File: rtl/trim_pulse_qual.sv
// Measures how long a level stays active, in ticks. Fires once, on the tick
// that completes WIDTH_TICKS. The level must then go inactive before the
// qualifier re-arms. hold clears the measurement and disarms.
module trim_pulse_qual #(
  parameter int WIDTH_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  input  logic hold,
  output logic fire
);
  localparam int CNT_W = $clog2(WIDTH_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH_TICKS - 1);

  logic             armed;
  logic [CNT_W-1:0] widthCnt;

  assign fire = !hold && armed && level && tick && (widthCnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      widthCnt <= '0;
    end else if (hold) begin
      armed    <= 1'b0;
      widthCnt <= '0;
    end else if (!level) begin
      armed    <= 1'b1;
      widthCnt <= '0;
    end else if (armed && tick) begin
      if (widthCnt == LAST) begin
        armed    <= 1'b0;
        widthCnt <= '0;
      end else begin
        widthCnt <= widthCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trim_ctl.sv
module trim_ctl
  import trim_pkg::*;
#(
  parameter int ACCEPT_TICKS = 200,
  parameter int GAP_TICKS    = 10,
  parameter int PROG_TICKS   = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cntEn,
  input  logic        lvlLow,
  input  logic        lvlHigh,
  input  logic        progFlag,
  input  logic        nvmBusy,
  output trimStrobe_t strobe,
  output logic        nvmRdEn,
  output logic        nvmWrEn,
  output logic        storing
);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);

  trimState_t       state, stateNx;
  logic [1:0]       lineAct, lineFire;
  logic             progFire, holdLine, runIdle;
  logic             countEvt, firstDone, gapOpen;
  logic [GAP_W-1:0] gapCnt;

  // bit 0: low excursion (count up), bit 1: high excursion (count down)
  assign lineAct  = {lvlHigh & ~lvlLow, lvlLow & ~lvlHigh};
  assign runIdle  = (state == ST_RUN);
  assign holdLine = !runIdle;
  assign storing  = (state == ST_WRSTB) || (state == ST_WRSETTLE) || (state == ST_WRWAIT);

  for (genvar g = 0; g < 2; g++) begin : g_line
    trim_pulse_qual #(.WIDTH_TICKS(ACCEPT_TICKS)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .level (lineAct[g]),
      .hold  (holdLine),
      .fire  (lineFire[g])
    );
  end

  trim_pulse_qual #(.WIDTH_TICKS(PROG_TICKS)) u_progQual (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .level (progFlag),
    .hold  (1'b0),
    .fire  (progFire)
  );

  assign gapOpen  = (gapCnt == '0);
  assign countEvt = runIdle && cntEn && gapOpen && (|lineFire) && !progFire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt    <= '0;
      firstDone <= 1'b0;
    end else if (countEvt) begin
      gapCnt    <= GAP_W'(GAP_TICKS);
      firstDone <= 1'b1;
    end else if (tick && !gapOpen) begin
      gapCnt    <= gapCnt - 1'b1;
    end
  end

  always_comb begin
    stateNx = state;
    strobe  = '0;
    nvmRdEn = 1'b0;
    nvmWrEn = 1'b0;
    case (state)
      ST_RDREQ: begin
        nvmRdEn = 1'b1;
        stateNx = ST_RDCAP;
      end
      ST_RDCAP: begin
        strobe.ldCode = 1'b1;
        stateNx       = ST_RUN;
      end
      ST_RUN: begin
        if (progFire) begin
          stateNx = ST_WRSTB;
        end else if (countEvt && firstDone) begin
          strobe.incCode = lineFire[0];
          strobe.decCode = lineFire[1];
        end
      end
      ST_WRSTB: begin
        nvmWrEn = 1'b1;
        stateNx = ST_WRSETTLE;
      end
      ST_WRSETTLE: stateNx = ST_WRWAIT;
      ST_WRWAIT: if (!nvmBusy) stateNx = ST_RUN;
      default: stateNx = ST_RDREQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RDREQ;
    else        state <= stateNx;
  end
endmodule

// File: rtl/trim_dp.sv
module trim_dp
  import trim_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trimStrobe_t       strobe,
  input  logic [CODE_W-1:0] nvmRdData,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 code <= '0;
    else if (strobe.ldCode)                     code <= nvmRdData;
    else if (strobe.incCode && code != MAXV)    code <= code + 1'b1;
    else if (strobe.decCode && code != '0)      code <= code - 1'b1;
  end
endmodule

// File: rtl/trim_ctl_top.sv
module trim_ctl_top
  import trim_pkg::*;
#(
  parameter int CODE_W       = 7,
  parameter int ACCEPT_TICKS = 200,
  parameter int GAP_TICKS    = 10,
  parameter int PROG_TICKS   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cntEn,
  input  logic              lvlLow,
  input  logic              lvlHigh,
  input  logic              progFlag,
  input  logic [CODE_W-1:0] nvmRdData,
  input  logic              nvmBusy,
  output logic [CODE_W-1:0] trimCode,
  output logic              nvmRdEn,
  output logic              nvmWrEn,
  output logic [CODE_W-1:0] nvmWrData,
  output logic              storing
);
  trimStrobe_t ctlStrobe;

  trim_ctl #(
    .ACCEPT_TICKS (ACCEPT_TICKS),
    .GAP_TICKS    (GAP_TICKS),
    .PROG_TICKS   (PROG_TICKS)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cntEn    (cntEn),
    .lvlLow   (lvlLow),
    .lvlHigh  (lvlHigh),
    .progFlag (progFlag),
    .nvmBusy  (nvmBusy),
    .strobe   (ctlStrobe),
    .nvmRdEn  (nvmRdEn),
    .nvmWrEn  (nvmWrEn),
    .storing  (storing)
  );

  trim_dp #(.CODE_W(CODE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (ctlStrobe),
    .nvmRdData (nvmRdData),
    .code      (trimCode)
  );

  assign nvmWrData = trimCode;
endmodule

// File: rtl/trim_ctl_chk.sv
module trim_ctl_chk
  import trim_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cntEn,
  input logic              storing,
  input logic              nvmWrEn,
  input logic              nvmBusy,
  input trimStrobe_t       strobe,
  input logic [CODE_W-1:0] trimCode
);
  localparam logic [CODE_W-1:0] MAXV = '1;

  // R2: an up strobe moves the code by exactly one unless already at the top
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incCode && trimCode != MAXV) |=> trimCode == $past(trimCode) + 1'b1);

  // R3: a down strobe moves the code by exactly one unless already at zero
  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.decCode && trimCode != '0) |=> trimCode == $past(trimCode) - 1'b1);

  // R6: saturation at both ends
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incCode && trimCode == MAXV) |=> trimCode == MAXV);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.decCode && trimCode == '0) |=> trimCode == '0);

  // R8: disabled counting holds the code
  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntEn && !strobe.ldCode) |=> $stable(trimCode));

  // R10: the code is frozen while a store runs
  a_r10_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    storing |=> $stable(trimCode));

  // R9: a write strobe is a single cycle, issued when storage is idle, and busy follows
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    nvmWrEn |=> (!nvmWrEn && storing));
  a_r9_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    nvmWrEn |-> !nvmBusy);
endmodule

bind trim_ctl_top trim_ctl_chk #(.CODE_W(CODE_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cntEn    (cntEn),
  .storing  (storing),
  .nvmWrEn  (nvmWrEn),
  .nvmBusy  (nvmBusy),
  .strobe   (ctlStrobe),
  .trimCode (trimCode)
);

// File: tb/trim_ctl_top_tb_top.sv
`timescale 1ns/1ps
module trim_ctl_top_tb_top;
  localparam int CW   = 7;
  localparam int ACC  = 4;
  localparam int GAP  = 6;
  localparam int PRG  = 5;
  localparam int BUSY = 80;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          cntEn = 1'b0;
  logic          lvlLow = 1'b0;
  logic          lvlHigh = 1'b0;
  logic          progFlag = 1'b0;
  logic [CW-1:0] nvmRdData;
  logic          nvmBusy;
  logic [CW-1:0] trimCode;
  logic          nvmRdEn, nvmWrEn, storing;
  logic [CW-1:0] nvmWrData;

  // storage model
  logic [CW-1:0] mem = '0;
  logic          doPreset = 1'b0;
  logic [CW-1:0] presetVal = '0;
  int            busyCnt = 0;
  int            wrCount = 0;

  int total = 0;
  int bad = 0;
  int expCode = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(negedge clk) tick <= ~tick;

  assign nvmRdData = mem;
  assign nvmBusy   = (busyCnt != 0);

  always @(posedge clk) begin
    if (doPreset) mem <= presetVal;
    else if (nvmWrEn) begin
      mem     <= nvmWrData;
      busyCnt <= BUSY;
      wrCount <= wrCount + 1;
    end else if (busyCnt > 0) busyCnt <= busyCnt - 1;
  end

  trim_ctl_top #(
    .CODE_W(CW), .ACCEPT_TICKS(ACC), .GAP_TICKS(GAP), .PROG_TICKS(PRG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cntEn(cntEn), .lvlLow(lvlLow),
    .lvlHigh(lvlHigh), .progFlag(progFlag), .nvmRdData(nvmRdData), .nvmBusy(nvmBusy),
    .trimCode(trimCode), .nvmRdEn(nvmRdEn), .nvmWrEn(nvmWrEn), .nvmWrData(nvmWrData),
    .storing(storing)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
    @(negedge clk);
  endtask

  // dir 0: low excursion, dir 1: high excursion
  task automatic pulse(input int dir, input int width);
    lvlLow  = (dir == 0);
    lvlHigh = (dir == 1);
    waitTicks(width);
    lvlLow  = 1'b0;
    lvlHigh = 1'b0;
    waitTicks(GAP + 2);
  endtask

  task automatic doReset(input bit preset, input int val);
    @(negedge clk);
    rst_n     = 1'b0;
    doPreset  = preset;
    presetVal = CW'(val);
    repeat (3) @(negedge clk);
    chk("R1 reset code", int'(trimCode), 0);
    chk("R1 reset storing", int'(storing), 0);
    doPreset = 1'b0;
    rst_n    = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int wr0;
    doReset(1'b1, 3);
    expCode = 3;
    chk("R1 power-on load", int'(trimCode), expCode);
    cntEn = 1'b1;

    pulse(0, ACC + 1);
    chk("R7 first pulse discarded", int'(trimCode), expCode);

    pulse(0, ACC - 1);
    chk("R4 short low ignored", int'(trimCode), expCode);
    pulse(1, ACC - 1);
    chk("R4 short high ignored", int'(trimCode), expCode);

    pulse(0, ACC + 1); expCode++;
    chk("R2 increment", int'(trimCode), expCode);
    pulse(1, ACC + 1); expCode--;
    chk("R3 decrement", int'(trimCode), expCode);

    cntEn = 1'b0;
    pulse(0, ACC + 1);
    chk("R8 disabled low", int'(trimCode), expCode);
    pulse(1, ACC + 1);
    chk("R8 disabled high", int'(trimCode), expCode);
    cntEn = 1'b1;

    for (int i = 0; i < 5; i++) begin
      pulse(1, ACC + 1);
      expCode = (expCode > 0) ? expCode - 1 : 0;
      chk("R6 down sweep to floor", int'(trimCode), expCode);
    end
    for (int i = 0; i < MAXC + 3; i++) begin
      pulse(0, ACC + 1);
      expCode = (expCode < MAXC) ? expCode + 1 : MAXC;
      chk("R2 R6 up sweep to ceiling", int'(trimCode), expCode);
    end

    // R5: high then low with no mid gap; the second completes inside the window
    lvlHigh = 1'b1;
    waitTicks(ACC + 1);
    lvlHigh = 1'b0;
    lvlLow  = 1'b1;
    waitTicks(ACC + 1);
    lvlLow  = 1'b0;
    waitTicks(GAP + 2);
    expCode--;
    chk("R5 second pulse inside spacing dropped", int'(trimCode), expCode);
    pulse(0, ACC + 1); expCode++;
    chk("R5 pulse after spacing counted", int'(trimCode), expCode);
    pulse(1, ACC + 1); expCode--;
    chk("R3 decrement from top", int'(trimCode), expCode);

    // R9: store, independent of enable
    cntEn = 1'b0;
    wr0 = wrCount;
    progFlag = 1'b1;
    waitTicks(PRG - 1);
    progFlag = 1'b0;
    waitTicks(4);
    chk("R9 short program hold no write", wrCount, wr0);

    progFlag = 1'b1;
    waitTicks(PRG + 1);
    chk("R9 storing asserted", int'(storing), 1);
    chk("R9 one write", wrCount, wr0 + 1);
    chk("R9 stored value", int'(mem), expCode);
    cntEn = 1'b1;
    pulse(0, ACC + 1);
    chk("R10 pulse during store ignored", int'(trimCode), expCode);
    chk("R9 storing held while busy", int'(storing), 1);
    waitTicks(BUSY / 2 + 5);
    chk("R9 storing released", int'(storing), 0);
    waitTicks(10);
    chk("R10 held flag no second write", wrCount, wr0 + 1);
    progFlag = 1'b0;
    waitTicks(10);
    chk("R10 no write after release", wrCount, wr0 + 1);
    pulse(0, ACC + 1); expCode++;
    chk("R10 counting resumes after store", int'(trimCode), expCode);

    // R1 / R7 again: reload from storage
    doReset(1'b0, 0);
    expCode = int'(mem);
    chk("R1 reload stored code", int'(trimCode), expCode);
    pulse(1, ACC + 1);
    chk("R7 first pulse discarded after reload", int'(trimCode), expCode);
    pulse(1, ACC + 1); expCode--;
    chk("R3 decrement after reload", int'(trimCode), expCode);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule